// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table held in external memory. The upper bits of the address select an entry in a root table that always sits at a fixed base address. That entry names the base of a second-level table, and the next field of the address selects the leaf entry in it. The leaf entry supplies the frame number, and the low bits of the virtual address pass through unchanged as the offset within the frame.

Every entry carries a present flag. A clear flag stops the walk at once and reports a fault together with the level that failed. A failed root lookup never causes the leaf table to be read. The walker has a single read port with a request/acknowledge handshake and issues one table read per level. A translation therefore costs two reads before the data access itself.

One walk runs at a time. A new request is taken only while the walker is idle. The result is reported with a one-cycle done pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: busy, mem_req and done are low, and ok and fault are low whenever done is low.
- R2: The first read of a walk goes to ROOT_BASE + 4 * vaddr[31:22].
- R3: The second read goes to {root_entry[31:12], 12'h000} + 4 * vaddr[21:12]. Root entry bits 11:1 have no effect on that address.
- R4: If root entry bit 0 (present) is 0, the walk ends with fault=1 and fault_level=0, and exactly one read is issued.
- R5: If leaf entry bit 0 is 0, the walk ends with fault=1 and fault_level=1 after exactly two reads. Leaf bits 11:1 do not change this outcome.
- R6: If both entries are present, the walk ends with ok=1 and paddr = {leaf_entry[31:12], vaddr[11:0]}.
- R7: Once raised, mem_req stays high with mem_addr unchanged until a cycle in which mem_ack is high.
- R8: done is high for exactly one cycle per walk. In that cycle exactly one of ok and fault is high.
- R9: busy rises on the cycle after an accepted request and stays high until done. req_valid is ignored while busy, and the walk in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request, taken only while idle |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress, result not yet reported |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 32 | Byte address of the table entry to read |
| mem_ack | input | 1 | Read data valid; completes the current request |
| mem_rdata | input | 32 | Table entry returned by memory |
| done | output | 1 | One-cycle pulse reporting the result |
| ok | output | 1 | Translation succeeded (valid with done) |
| fault | output | 1 | Entry not present (valid with done) |
| fault_level | output | 1 | 0 = root entry absent, 1 = leaf entry absent |
| paddr | output | 32 | Physical address (valid with done and ok) |

## Verification
The assertions assume that memory raises mem_ack only while mem_req is high, for one cycle per read, and that mem_rdata is valid in that cycle. The read counts checked at done depend on this. The bench memory model waits for mem_req, inserts a per-walk delay of zero to three cycles, and then gives a single-cycle acknowledge with the stored entry. Stored entries include cases with stray low flag bits and cases with the present bit cleared, so both fault levels are exercised. Requests are driven while the walker is busy to confirm they are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROOT = 2'd1,
    ST_LEAF = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;

  localparam logic LVL_ROOT = 1'b0;
  localparam logic LVL_LEAF = 1'b1;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned NUM_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0] entry,
  output logic             present,
  output logic [NUM_W-1:0] base_num
);

  // Bits OFF_W-1:1 are flags that the walk does not interpret.
  logic [OFF_W-2:0] flags_unused;

  assign present      = entry[0];
  assign base_num     = entry[PTE_W-1:OFF_W];
  assign flags_unused = entry[OFF_W-1:1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned   VA_W       = 32,
  parameter int unsigned   ROOT_IDX_W = 10,
  parameter int unsigned   LEAF_IDX_W = 10,
  parameter int unsigned   OFF_W      = 12,
  parameter int unsigned   PTE_BYTES  = 4,
  parameter logic [VA_W-1:0] ROOT_BASE = '0,
  localparam int unsigned  NUM_W  = VA_W - OFF_W,
  localparam int unsigned  IDX_SH = $clog2(PTE_BYTES)
) (
  input  walk_state_e      state,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [NUM_W-1:0] tbl_num,
  output logic [VA_W-1:0]  mem_addr
);

  logic [ROOT_IDX_W-1:0] root_idx;
  logic [LEAF_IDX_W-1:0] leaf_idx;
  logic [VA_W-1:0]       root_addr;
  logic [VA_W-1:0]       leaf_addr;
  logic [VA_W-1:0]       tbl_base;

  assign root_idx = vaddr[VA_W-1 -: ROOT_IDX_W];
  assign leaf_idx = vaddr[OFF_W +: LEAF_IDX_W];
  assign tbl_base = {tbl_num, {OFF_W{1'b0}}};

  assign root_addr = ROOT_BASE + (VA_W'(root_idx) << IDX_SH);
  assign leaf_addr = tbl_base  + (VA_W'(leaf_idx) << IDX_SH);

  always_comb begin
    if (state == ST_LEAF) mem_addr = leaf_addr;
    else                  mem_addr = root_addr;
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_ack,
  input  logic        entry_present,
  output walk_state_e state_q,
  output logic        accept,
  output logic        root_take,
  output logic        leaf_take,
  output logic        finish
);

  walk_state_e state_d;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign root_take = (state_q == ST_ROOT) && mem_ack;
  assign leaf_take = (state_q == ST_LEAF) && mem_ack;
  assign finish    = (root_take && !entry_present) || leaf_take;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_ROOT;
      ST_ROOT: begin
        if (mem_ack) begin
          if (entry_present) state_d = ST_LEAF;
          else               state_d = ST_DONE;
        end
      end
      ST_LEAF: if (mem_ack) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned     VA_W       = 32,
  parameter int unsigned     ROOT_IDX_W = 10,
  parameter int unsigned     LEAF_IDX_W = 10,
  parameter int unsigned     OFF_W      = 12,
  parameter logic [VA_W-1:0] ROOT_BASE  = 32'h0001_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            busy,
  output logic            mem_req,
  output logic [VA_W-1:0] mem_addr,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            done,
  output logic            ok,
  output logic            fault,
  output logic            fault_level,
  output logic [VA_W-1:0] paddr
);

  localparam int unsigned PTE_W     = VA_W;
  localparam int unsigned PTE_BYTES = PTE_W / 8;
  localparam int unsigned NUM_W     = VA_W - OFF_W;

  logic             rst_n_int;
  walk_state_e      state_q;
  logic             accept;
  logic             root_take;
  logic             leaf_take;
  logic             finish;
  logic             ent_present;
  logic [NUM_W-1:0] ent_num;

  logic [VA_W-1:0]  vaddr_q;
  logic [NUM_W-1:0] tbl_num_q;
  logic             ok_q;
  logic             lvl_q;
  logic [VA_W-1:0]  paddr_q;

  ptw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ptw_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .req_valid     (req_valid),
    .mem_ack       (mem_ack),
    .entry_present (ent_present),
    .state_q       (state_q),
    .accept        (accept),
    .root_take     (root_take),
    .leaf_take     (leaf_take),
    .finish        (finish)
  );

  ptw_entry_dec #(
    .PTE_W (PTE_W),
    .OFF_W (OFF_W)
  ) u_dec (
    .entry    (mem_rdata),
    .present  (ent_present),
    .base_num (ent_num)
  );

  ptw_addr_gen #(
    .VA_W       (VA_W),
    .ROOT_IDX_W (ROOT_IDX_W),
    .LEAF_IDX_W (LEAF_IDX_W),
    .OFF_W      (OFF_W),
    .PTE_BYTES  (PTE_BYTES),
    .ROOT_BASE  (ROOT_BASE)
  ) u_agen (
    .state    (state_q),
    .vaddr    (vaddr_q),
    .tbl_num  (tbl_num_q),
    .mem_addr (mem_addr)
  );

  // Datapath registers carry no reset; each has an explicit enable.
  always_ff @(posedge clk) begin
    if (accept) vaddr_q <= req_vaddr;
  end

  always_ff @(posedge clk) begin
    if (root_take) tbl_num_q <= ent_num;
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      ok_q  <= leaf_take && ent_present;
      lvl_q <= leaf_take ? LVL_LEAF : LVL_ROOT;
      if (leaf_take && ent_present) paddr_q <= {ent_num, vaddr_q[OFF_W-1:0]};
      else                          paddr_q <= '0;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign mem_req     = (state_q == ST_ROOT) || (state_q == ST_LEAF);
  assign done        = (state_q == ST_DONE);
  assign ok          = done && ok_q;
  assign fault       = done && !ok_q;
  assign fault_level = done && !ok_q && lvl_q;
  assign paddr       = paddr_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic mem_req,
  input logic [31:0] mem_addr,
  input logic mem_ack,
  input logic done,
  input logic ok,
  input logic fault,
  input logic fault_level
);

  logic [1:0] ack_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ack_cnt <= 2'd0;
    else if (!busy)               ack_cnt <= 2'd0;
    else if (mem_req && mem_ack && ack_cnt != 2'd3) ack_cnt <= ack_cnt + 2'd1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

  a_r1_flags_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!ok && !fault));

  a_r4_root_fault_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault && !fault_level) |-> (ack_cnt == 2'd1));

  a_r5_leaf_fault_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault && fault_level) |-> (ack_cnt == 2'd2));

  a_r6_ok_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> (ack_cnt == 2'd2));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({ok, fault}) == 1);

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r9_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> !busy);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .busy        (busy),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .done        (done),
  .ok          (ok),
  .fault       (fault),
  .fault_level (fault_level)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RBASE = 32'h0001_0000;

  typedef struct packed {
    logic [31:0] va;
    logic        exp_ok;
    logic        exp_lvl;
    logic [31:0] exp_pa;
    logic [1:0]  exp_reads;
    logic [31:0] exp_ra;
    logic [31:0] exp_la;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_5123, 1'b1, 1'b0, 32'hABCD_E123, 2'd2, 32'h0001_0004, 32'h0002_0014},
    '{32'h0040_6000, 1'b0, 1'b1, 32'h0000_0000, 2'd2, 32'h0001_0004, 32'h0002_0018},
    '{32'h0080_5000, 1'b0, 1'b0, 32'h0000_0000, 2'd1, 32'h0001_0008, 32'h0000_0000},
    '{32'h00C0_0000, 1'b1, 1'b0, 32'h1234_5000, 2'd2, 32'h0001_000C, 32'h0003_0000},
    '{32'h00FF_F001, 1'b1, 1'b0, 32'hFFFF_F001, 2'd2, 32'h0001_000C, 32'h0003_0FFC},
    '{32'hFFC0_0800, 1'b1, 1'b0, 32'h0000_0800, 2'd2, 32'h0001_0FFC, 32'h0004_0000},
    '{32'h0000_0FFF, 1'b0, 1'b0, 32'h0000_0000, 2'd1, 32'h0001_0000, 32'h0000_0000},
    '{32'h00C0_2ABC, 1'b0, 1'b1, 32'h0000_0000, 2'd2, 32'h0001_000C, 32'h0003_0008}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        busy;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done;
  logic        ok;
  logic        fault;
  logic        fault_level;
  logic [31:0] paddr;

  int total;
  int bad;
  int lat;
  int nreads;
  logic [31:0] rd_addr [4];
  logic [31:0] pmem [logic [31:0]];

  logic        r_ok, r_fault, r_lvl, r_seen;
  logic [31:0] r_pa;

  ptw_walker #(.ROOT_BASE(RBASE)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .ok          (ok),
    .fault       (fault),
    .fault_level (fault_level),
    .paddr       (paddr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: single-cycle acknowledge after lat idle cycles.
  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat (lat) @(negedge clk);
        if (nreads < 4) rd_addr[nreads] = mem_addr;
        nreads    = nreads + 1;
        mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
        mem_ack   = 1'b1;
        @(negedge clk);
        mem_ack   = 1'b0;
        mem_rdata = '0;
      end
    end
  end

  task automatic check(input logic cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Launch a request and wait for the done pulse, sampling on falling edges.
  task automatic walk(input logic [31:0] va);
    nreads = 0;
    for (int k = 0; k < 4; k++) rd_addr[k] = '0;
    r_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 60 && !r_seen; c++) begin
      if (done) begin
        r_seen  = 1'b1;
        r_ok    = ok;
        r_fault = fault;
        r_lvl   = fault_level;
        r_pa    = paddr;
      end else begin
        @(negedge clk);
      end
    end
    check(r_seen, "R8", "done seen", {31'b0, r_seen}, 32'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad = 0;
    lat = 0;
    nreads = 0;
    req_valid = 1'b0;
    req_vaddr = '0;
    rst_n = 1'b0;

    // Table contents
    pmem[32'h0001_0004] = 32'h0002_0001;
    pmem[32'h0001_000C] = 32'h0003_0FFF;  // flag bits set in 11:1
    pmem[32'h0001_0FFC] = 32'h0004_0001;
    pmem[32'h0002_0014] = 32'hABCD_E001;
    pmem[32'h0003_0000] = 32'h1234_5FFF;
    pmem[32'h0003_0FFC] = 32'hFFFF_F001;
    pmem[32'h0003_0008] = 32'h7777_7FFE;  // not present, other flags set
    pmem[32'h0004_0000] = 32'h0000_0001;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy, "R1", "busy in reset", {31'b0, busy}, 32'h0);
    check(!mem_req, "R1", "mem_req in reset", {31'b0, mem_req}, 32'h0);
    check(!done && !ok && !fault, "R1", "done/ok/fault in reset",
          {29'b0, done, ok, fault}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !mem_req, "R1", "idle after release",
          {30'b0, busy, mem_req}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      lat = i % 4;
      walk(VECS[i].va);
      check(r_ok == VECS[i].exp_ok, VECS[i].exp_ok ? "R6" : "R4",
            "ok flag", {31'b0, r_ok}, {31'b0, VECS[i].exp_ok});
      check(r_fault == !VECS[i].exp_ok, "R8", "fault flag",
            {31'b0, r_fault}, {31'b0, !VECS[i].exp_ok});
      check(nreads == int'(VECS[i].exp_reads), VECS[i].exp_reads == 2'd1 ? "R4" : "R5",
            "read count", nreads, {30'b0, VECS[i].exp_reads});
      check(rd_addr[0] == VECS[i].exp_ra, "R2", "root read address",
            rd_addr[0], VECS[i].exp_ra);
      if (VECS[i].exp_reads == 2'd2)
        check(rd_addr[1] == VECS[i].exp_la, "R3", "leaf read address",
              rd_addr[1], VECS[i].exp_la);
      if (VECS[i].exp_ok)
        check(r_pa == VECS[i].exp_pa, "R6", "physical address", r_pa, VECS[i].exp_pa);
      else
        check(r_lvl == VECS[i].exp_lvl, VECS[i].exp_lvl ? "R5" : "R4",
              "fault level", {31'b0, r_lvl}, {31'b0, VECS[i].exp_lvl});
    end

    // R9: requests while busy are ignored
    lat = 3;
    nreads = 0;
    r_seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = VECS[0].va;
    @(negedge clk);
    check(busy, "R9", "busy after accept", {31'b0, busy}, 32'h1);
    req_vaddr = VECS[2].va;  // must not disturb the walk
    for (int c = 0; c < 60 && !r_seen; c++) begin
      if (done) begin
        r_seen = 1'b1;
        r_ok   = ok;
        r_pa   = paddr;
      end else begin
        @(negedge clk);
      end
    end
    req_valid = 1'b0;
    check(r_ok && r_pa == 32'hABCD_E123, "R9", "first walk result kept",
          r_pa, 32'hABCD_E123);
    check(nreads == 2, "R9", "reads of ignored request", nreads, 32'd2);
    @(negedge clk);
    @(negedge clk);
    check(!busy && !done, "R8", "single done pulse", {30'b0, busy, done}, 32'h0);

    // R7: request held while memory stalls
    lat = 3;
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = VECS[5].va;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(mem_req && mem_addr == 32'h0001_0FFC, "R7", "held root request",
          mem_addr, 32'h0001_0FFC);
    @(negedge clk);
    check(mem_req && mem_addr == 32'h0001_0FFC, "R7", "still held",
          mem_addr, 32'h0001_0FFC);
    for (int c = 0; c < 60 && !done; c++) @(negedge clk);
    check(ok && paddr == 32'h0000_0800, "R6", "stalled walk result", paddr, 32'h0000_0800);
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule